// File: doc/BRIEF.md
# Palette Colour Lookup Loader

This block holds a colour lookup table of 256 entries, each made of an 8-bit red, green and blue value. It is loaded through a small byte-addressed write port and read through a separate pixel port. Software first writes a starting entry number to the index register. It then streams colour bytes into the colour-data register. Each byte goes to red, green or blue of the selected entry in turn. After a blue byte the entry number moves on by one, so a whole table can be loaded with one index write followed by a continuous stream of colour bytes.

A colour-data write is either a single byte or a full 32-bit word. A word is unpacked into four successive colour bytes, most significant byte first, so one word can cross from one entry into the next. The pixel port takes an 8-bit pixel value and returns its packed 24-bit colour one clock later. A one-cycle pulse marks every colour-data write, so that downstream logic can redraw the whole frame.

Top module: `clut_dac_regs`

## Requirements
- R1: A write to offset 0x0 loads `bus_wdata[7:0]` as the current entry index and puts the colour phase back to red, whatever the phase was before.
- R2: A byte write (`bus_wide`=0) to offset 0x4 stores `bus_wdata[7:0]` into the colour of the current phase (red, then green, then blue) at the current entry. Red and green stores advance the phase and leave the index unchanged.
- R3: A blue store returns the phase to red and increments the index modulo 256, so index 255 is followed by index 0.
- R4: A word write (`bus_wide`=1) to offset 0x4 acts as four byte stores, taking bits 31:24 first, then 23:16 and 15:8, and bits 7:0 last. The stores continue across entry boundaries and advance the phase by four steps in total.
- R5: Any index sampled on `pix_idx` at a clock edge gives `pix_rgb` = {red, green, blue} of that entry (bits 23:16, 15:8, 7:0) after that edge.
- R6: A synchronous reset clears every red, green and blue entry to zero, sets the phase to red and sets the index to 0.
- R7: `pal_changed` is high for exactly the cycle after each write to offset 0x4 and is low after any other cycle.
- R8: `bus_rdata` reads as zero for both register offsets at all times.
- R9: Writes to offsets other than 0x0 and 0x4 change neither the index, the phase nor any table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register written |
| bus_wide | input | 1 | 1: 32-bit word write, 0: byte write in bits 7:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | IDX_W | Pixel value to look up |
| pix_rgb | output | 24 | Packed colour of the registered pixel value |
| pal_changed | output | 1 | One-cycle pulse after each colour-data write |

## Verification
Loading is tried with pure byte streams, with word writes that start in each of the three phases, and with byte and word writes mixed. This tells apart byte order inside a word and the phase carried between writes. A word starting on blue places two blue stores into neighbouring entries in the same cycle. This separates a correct two-bank split from one that drops or misplaces a byte. A stream that crosses from entry 255 into entry 0, an index rewrite in the middle of an entry, a write to an unused offset and a reset in the middle of a load each check one wrap, restart or clear rule.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int NCH        = 3;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = 8 * WORD_BYTES;
  localparam int CH_W       = 8;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  function automatic phase_t step_phase(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  idx_wr,
  input  logic                                  cmap_wr,
  input  logic                                  cmap_wide,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [NCH-1:0][1:0]                   bank_we,
  output logic [NCH-1:0][1:0][IDX_W-2:0]        bank_addr,
  output logic [NCH-1:0][1:0][CH_W-1:0]         bank_data,
  output phase_t                                cur_phase,
  output logic [IDX_W-1:0]                      cur_idx
);

  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;

  // Unpack up to four colour bytes; each lands in one channel and one
  // parity bank. Within one word no channel/bank pair is hit twice.
  always_comb begin
    bank_we   = '0;
    bank_addr = '0;
    bank_data = '0;
    for (int k = 0; k < WORD_BYTES; k++) begin
      logic [2:0]       pos;
      logic [1:0]       ch;
      logic [IDX_W-1:0] slot;
      logic [CH_W-1:0]  val;
      pos  = {1'b0, phase_q} + 3'(k);
      ch   = (pos >= 3'd3) ? 2'(pos - 3'd3) : pos[1:0];
      slot = idx_q + ((pos >= 3'd3) ? IDX_W'(1) : IDX_W'(0));
      val  = cmap_wide ? wdata[DATA_W-1-CH_W*k -: CH_W] : wdata[CH_W-1:0];
      if (cmap_wr && (cmap_wide || k == 0)) begin
        bank_we  [ch][slot[0]] = 1'b1;
        bank_addr[ch][slot[0]] = slot[IDX_W-1:1];
        bank_data[ch][slot[0]] = val;
      end
    end
  end

  logic [IDX_W-1:0] idx_step;
  always_comb begin
    idx_step = (phase_q == PH_BLU) ? IDX_W'(1) : IDX_W'(0);
    if (cmap_wide) idx_step = idx_step + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
    end else if (idx_wr) begin
      phase_q <= PH_RED;
      idx_q   <= wdata[IDX_W-1:0];
    end else if (cmap_wr) begin
      phase_q <= step_phase(phase_q);
      idx_q   <= idx_q + idx_step;
    end
  end

  assign cur_phase = phase_q;
  assign cur_idx   = idx_q;

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int AW = 7,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [W-1:0]     rd_q;
  logic             rd_ok_q;

  // Plain memory, no reset: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  // Per-entry written flags give an instant clear on reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      rd_ok_q <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      rd_ok_q <= written[raddr];
    end
  end

  assign rdata = rd_ok_q ? rd_q : '0;

endmodule

// File: rtl/clut_channel.sv
module clut_channel
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                we,
  input  logic [1:0][IDX_W-2:0]     waddr,
  input  logic [1:0][CH_W-1:0]      wdata,
  input  logic [IDX_W-1:0]          ridx,
  output logic [CH_W-1:0]           rval
);

  logic [1:0][CH_W-1:0] bank_out;
  logic                 odd_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    clut_bank #(.AW(IDX_W-1), .W(CH_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (we[b]),
      .waddr (waddr[b]),
      .wdata (wdata[b]),
      .raddr (ridx[IDX_W-1:1]),
      .rdata (bank_out[b])
    );
  end

  always_ff @(posedge clk) odd_q <= ridx[0];

  assign rval = odd_q ? bank_out[1] : bank_out[0];

endmodule

// File: rtl/clut_dac_regs.sv
module clut_dac_regs
  import clut_pkg::*;
#(
  parameter int          IDX_W    = 8,
  parameter int          ADDR_W   = 5,
  parameter logic [4:0]  OFS_INDEX = 5'h00,
  parameter logic [4:0]  OFS_CMAP  = 5'h04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wide,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic [23:0]        pix_rgb,
  output logic               pal_changed
);

  logic idx_wr;
  logic cmap_wr;

  assign idx_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_INDEX));
  assign cmap_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMAP));

  logic [NCH-1:0][1:0]                 bank_we;
  logic [NCH-1:0][1:0][IDX_W-2:0]      bank_addr;
  logic [NCH-1:0][1:0][CH_W-1:0]       bank_data;
  phase_t                              cur_phase;
  logic [IDX_W-1:0]                    cur_idx;

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .idx_wr    (idx_wr),
    .cmap_wr   (cmap_wr),
    .cmap_wide (bus_wide),
    .wdata     (bus_wdata),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_data (bank_data),
    .cur_phase (cur_phase),
    .cur_idx   (cur_idx)
  );

  logic [NCH-1:0][CH_W-1:0] ch_val;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    clut_channel #(.IDX_W(IDX_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .we    (bank_we[c]),
      .waddr (bank_addr[c]),
      .wdata (bank_data[c]),
      .ridx  (pix_idx),
      .rval  (ch_val[c])
    );
  end

  // Channel 0 is red and sits in the top byte.
  assign pix_rgb = {ch_val[0], ch_val[1], ch_val[2]};

  always_ff @(posedge clk) begin
    if (rst) pal_changed <= 1'b0;
    else     pal_changed <= cmap_wr;
  end

  assign bus_rdata = '0;

endmodule

// File: rtl/clut_dac_regs_chk.sv
module clut_dac_regs_chk
  import clut_pkg::*;
#(
  parameter int         IDX_W     = 8,
  parameter int         ADDR_W    = 5,
  parameter logic [4:0] OFS_INDEX = 5'h00,
  parameter logic [4:0] OFS_CMAP  = 5'h04
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wide,
  input logic [31:0]       bus_wdata,
  input logic              pal_changed,
  input phase_t            cur_phase,
  input logic [IDX_W-1:0]  cur_idx
);

  logic hit_idx, hit_cmap, hit_other;
  assign hit_idx   = bus_wr && bus_addr == ADDR_W'(OFS_INDEX);
  assign hit_cmap  = bus_wr && bus_addr == ADDR_W'(OFS_CMAP);
  assign hit_other = bus_wr && !hit_idx && !hit_cmap;

  assert_index_load_R1: assert property (@(posedge clk) disable iff (rst)
    hit_idx |=> (cur_phase == PH_RED && cur_idx == $past(bus_wdata[IDX_W-1:0])));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    hit_cmap |=> cur_phase == step_phase($past(cur_phase)));

  assert_byte_index_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_cmap && !bus_wide) |=>
      cur_idx == $past(cur_idx) + (($past(cur_phase) == PH_BLU) ? IDX_W'(1) : IDX_W'(0)));

  assert_word_index_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_cmap && bus_wide) |=>
      cur_idx == $past(cur_idx) + (($past(cur_phase) == PH_BLU) ? IDX_W'(2) : IDX_W'(1)));

  assert_reset_state_R6: assert property (@(posedge clk)
    rst |=> (cur_phase == PH_RED && cur_idx == '0 && !pal_changed));

  assert_pulse_on_R7: assert property (@(posedge clk) disable iff (rst)
    hit_cmap |=> pal_changed);

  assert_pulse_off_R7: assert property (@(posedge clk) disable iff (rst)
    !hit_cmap |=> !pal_changed);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    hit_other |=> ($stable(cur_idx) && $stable(cur_phase)));

endmodule

bind clut_dac_regs clut_dac_regs_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .OFS_INDEX(OFS_INDEX), .OFS_CMAP(OFS_CMAP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wide    (bus_wide),
  .bus_wdata   (bus_wdata),
  .pal_changed (pal_changed),
  .cur_phase   (cur_phase),
  .cur_idx     (cur_idx)
);

// File: tb/clut_dac_regs_test.sv
module clut_dac_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wide = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        pal_changed;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clut_dac_regs uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb), .pal_changed(pal_changed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write cycle; pal_changed is sampled in the cycle after the edge.
  task automatic wr(input logic [4:0] a, input logic wide, input logic [31:0] d,
                    input string req, input logic exp_pulse);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b0;
    check(req, 32'(pal_changed), 32'(exp_pulse));
  endtask

  task automatic look(input logic [7:0] p, input logic [23:0] exp, input string req);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    check(req, 32'(pix_rgb), 32'(exp));
  endtask

  // kind: 0 index write, 1 byte write, 2 word write, 3 lookup
  // {kind[1:0], data[31:0], expected colour[23:0]}
  localparam int NVEC = 23;
  localparam logic [57:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0010, 24'h0},
    {2'd2, 32'h1122_3344, 24'h0},
    {2'd1, 32'h0000_0055, 24'h0},
    {2'd1, 32'h0000_0066, 24'h0},
    {2'd3, 32'h0000_0010, 24'h112233},
    {2'd3, 32'h0000_0011, 24'h445566},
    {2'd0, 32'h0000_00FF, 24'h0},
    {2'd1, 32'h0000_00A1, 24'h0},
    {2'd1, 32'h0000_00A2, 24'h0},
    {2'd1, 32'h0000_00A3, 24'h0},
    {2'd1, 32'h0000_00B1, 24'h0},
    {2'd2, 32'hC1C2_C3C4, 24'h0},
    {2'd2, 32'hD1D2_D3D4, 24'h0},
    {2'd3, 32'h0000_00FF, 24'hA1A2A3},
    {2'd3, 32'h0000_0000, 24'hB1C1C2},
    {2'd3, 32'h0000_0001, 24'hC3C4D1},
    {2'd3, 32'h0000_0002, 24'hD2D3D4},
    {2'd3, 32'h0000_0003, 24'h000000},
    {2'd0, 32'h0000_0040, 24'h0},
    {2'd1, 32'h0000_0077, 24'h0},
    {2'd0, 32'h0000_0040, 24'h0},
    {2'd1, 32'h0000_0088, 24'h0},
    {2'd3, 32'h0000_0040, 24'h880000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state (R6, R7, R8)
    check("R7 reset pulse", 32'(pal_changed), 32'h0);
    check("R8 rdata", bus_rdata, 32'h0);
    look(8'h00, 24'h0, "R6 reset entry 00");
    look(8'h7F, 24'h0, "R6 reset entry 7F");
    look(8'hFF, 24'h0, "R6 reset entry FF");

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  kind;
      logic [31:0] d;
      logic [23:0] e;
      {kind, d, e} = VEC[i];
      case (kind)
        2'd0: wr(5'h00, 1'b0, d, "R1 R7 index write", 1'b0);
        2'd1: wr(5'h04, 1'b0, d, "R2 R7 byte write", 1'b1);
        2'd2: wr(5'h04, 1'b1, d, "R4 R7 word write", 1'b1);
        default: look(d[7:0], e, "R2 R3 R4 R5 table lookup");
      endcase
    end
    check("R8 rdata after loads", bus_rdata, 32'h0);

    // Write to an unused offset moves nothing (R9); phase is green at 0x40
    wr(5'h08, 1'b1, 32'hDEAD_BEEF, "R9 R7 unused offset", 1'b0);
    wr(5'h10, 1'b0, 32'h0000_0033, "R9 R7 unused offset", 1'b0);
    look(8'h40, 24'h880000, "R9 entry untouched");
    wr(5'h04, 1'b0, 32'h0000_0099, "R2 byte after ignored", 1'b1);
    look(8'h40, 24'h889900, "R9 index and phase kept");

    // Reset in the middle of an entry clears everything (R6)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(8'h40, 24'h0, "R6 cleared 40");
    look(8'h10, 24'h0, "R6 cleared 10");
    wr(5'h04, 1'b0, 32'h0000_00EE, "R6 R7 byte after reset", 1'b1);
    look(8'h00, 24'hEE0000, "R6 phase red index 0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule